// File: doc/BRIEF.md
# 24-bit Accumulator ALU with Condition Flags

This block is the arithmetic and logic stage for a 24-bit accumulator. Each cycle in which `in_valid` is high, it takes an 8-bit opcode, the current accumulator value, a register operand and an 8-bit immediate. One cycle later it presents the new accumulator value and four condition flags:

- negative (N)
- zero (Z)
- greater-or-equal / no-borrow (T)
- signed overflow (V)

Each flag is held until an operation that affects it arrives.

The opcode chooses the operation. Opcode bit 2 picks the immediate, zero-extended, in place of the register operand. Opcode bits 1:0 shift that operand left before an arithmetic, compare or logic operation. Compare operations set the flags and pass the accumulator through unchanged. Logic operations, shifts and sign extensions touch only N and Z. Multiplication and the register file sit outside this block.

Top module: `flag_alu24`

## Requirements
- R1: While `rst_n` is low, `acc_out`, `out_valid` and all four flags are 0.
- R2: `out_valid` equals `in_valid` one clock earlier. In a cycle with `in_valid` low, `acc_out` and all flags keep their values.
- R3: Operand source:
  - With opcode bit 2 set, the operand is `{16'h0, imm_in}`. With it clear, the operand is `reg_in`.
  - Before arithmetic, compare and logic operations, the operand is shifted left by 0, 1, 8 or 16 bits for opcode[1:0] = 0, 1, 2, 3, and truncated to 24 bits.
- R4: Opcode[7:3] = 10000 gives A+op, 10010 gives A-op, and 10001 gives op-A, each written to `acc_out`.
- R5: For the three arithmetic operations:
  - N = result bit 23, and Z = (result == 0).
  - V = signed 24-bit overflow.
  - T = carry out for addition, and no-borrow (minuend ≥ subtrahend, unsigned) for subtraction.
- R6: Opcode[7:3] = 01010 (A-op) and 01001 (op-A) set N, Z, T and V as for subtraction, and `acc_out` takes `acc_in` unchanged.
- R7: Opcode[7:3] = 10100 gives A ^ ~op, 10101 gives A ^ op, 10110 gives A & op, and 10111 gives A | op. Each updates N and Z only, and T and V hold.
- R8: Shift operations:
  - Opcode[7:3] = 11000 is a logical right shift, 11001 an arithmetic right shift, 11010 a right rotate, and 11011 a left shift.
  - The amount is `imm_in[4:0]` when opcode bit 2 is set, otherwise all of `reg_in`. Opcode[1:0] has no effect.
  - Shifts update N and Z only.
- R9: For a shift amount of 24 or more, a logical shift gives 0 and an arithmetic right shift gives 24 copies of A[23]. A rotate uses the amount modulo 24.
- R10: Opcode 8'h59 sign-extends A from bit 7 and 8'h5A sign-extends A from bit 15. Both update N and Z only.
- R11: Any other opcode gives `acc_out` = `acc_in` and leaves all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| opcode | input | 8 | Upper instruction byte |
| acc_in | input | 24 | Current accumulator |
| reg_in | input | 24 | Register operand / register shift amount |
| imm_in | input | 8 | Immediate byte |
| out_valid | output | 1 | Result valid, one cycle after strobe |
| acc_out | output | 24 | New accumulator value |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_t | output | 1 | Greater-or-equal / no-borrow flag |
| flag_v | output | 1 | Signed overflow flag |

## Verification
Every one of the 256 opcodes is swept against accumulator values at the signed and unsigned extremes and against operands chosen around the pre-shift and shift-count boundaries. This sweep catches several classes of error:

- An operand taken from the wrong source, or pre-shifted by the wrong amount, gives wrong sums.
- A V that only tests carry, or a T with inverted borrow sense, misreports the crossing of 7FFFFF/800000.
- A logic op or shift that clobbers T or V is exposed, because the preceding arithmetic leaves those flags set.

Register shift amounts of 24, 25 and 47 expose a shifter that wraps the count instead of saturating, or a rotate that is not reduced modulo 24. Unused opcodes and idle cycles show any design that updates flags or the accumulator when it should hold.

// File: rtl/flag_alu24.sv
module flag_alu24 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  opcode,
  input  logic [23:0] acc_in,
  input  logic [23:0] reg_in,
  input  logic [7:0]  imm_in,
  output logic        out_valid,
  output logic [23:0] acc_out,
  output logic        flag_n,
  output logic        flag_z,
  output logic        flag_t,
  output logic        flag_v
);

  logic [4:0]  grp;
  logic [23:0] src, opb, shamt, rotk, res, fres;
  logic [24:0] sum, a_m_b, b_m_a;
  logic        upd_nz, upd_tv, t_nx, v_nx;

  assign grp   = opcode[7:3];
  assign src   = opcode[2] ? {16'd0, imm_in} : reg_in;
  assign shamt = opcode[2] ? {19'd0, imm_in[4:0]} : reg_in;
  assign rotk  = shamt % 24'd24;

  always_comb begin
    case (opcode[1:0])
      2'd0:    opb = src;
      2'd1:    opb = {src[22:0], 1'b0};
      2'd2:    opb = {src[15:0], 8'd0};
      default: opb = {src[7:0], 16'd0};
    endcase
  end

  assign sum   = {1'b0, acc_in} + {1'b0, opb};
  assign a_m_b = {1'b0, acc_in} - {1'b0, opb};
  assign b_m_a = {1'b0, opb} - {1'b0, acc_in};

  always_comb begin
    res    = acc_in;
    fres   = acc_in;
    upd_nz = 1'b0;
    upd_tv = 1'b0;
    t_nx   = flag_t;
    v_nx   = flag_v;
    case (grp)
      5'b10000: begin
        res = sum[23:0]; fres = res; upd_nz = 1'b1; upd_tv = 1'b1;
        t_nx = sum[24];
        v_nx = (acc_in[23] == opb[23]) && (sum[23] != acc_in[23]);
      end
      5'b10010, 5'b01010: begin
        res  = (grp == 5'b10010) ? a_m_b[23:0] : acc_in;
        fres = a_m_b[23:0]; upd_nz = 1'b1; upd_tv = 1'b1;
        t_nx = ~a_m_b[24];
        v_nx = (acc_in[23] != opb[23]) && (a_m_b[23] != acc_in[23]);
      end
      5'b10001, 5'b01001: begin
        res  = (grp == 5'b10001) ? b_m_a[23:0] : acc_in;
        fres = b_m_a[23:0]; upd_nz = 1'b1; upd_tv = 1'b1;
        t_nx = ~b_m_a[24];
        v_nx = (opb[23] != acc_in[23]) && (b_m_a[23] != opb[23]);
      end
      5'b01011: begin
        if (opcode[2:0] == 3'd1) begin
          res = {{16{acc_in[7]}}, acc_in[7:0]}; fres = res; upd_nz = 1'b1;
        end else if (opcode[2:0] == 3'd2) begin
          res = {{8{acc_in[15]}}, acc_in[15:0]}; fres = res; upd_nz = 1'b1;
        end
      end
      5'b10100: begin res = acc_in ^ ~opb; fres = res; upd_nz = 1'b1; end
      5'b10101: begin res = acc_in ^ opb;  fres = res; upd_nz = 1'b1; end
      5'b10110: begin res = acc_in & opb;  fres = res; upd_nz = 1'b1; end
      5'b10111: begin res = acc_in | opb;  fres = res; upd_nz = 1'b1; end
      5'b11000: begin res = acc_in >> shamt; fres = res; upd_nz = 1'b1; end
      5'b11001: begin res = $signed(acc_in) >>> shamt; fres = res; upd_nz = 1'b1; end
      5'b11010: begin
        res = (acc_in >> rotk) | (acc_in << (24'd24 - rotk)); fres = res; upd_nz = 1'b1;
      end
      5'b11011: begin res = acc_in << shamt; fres = res; upd_nz = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      acc_out   <= '0;
      flag_n    <= 1'b0;
      flag_z    <= 1'b0;
      flag_t    <= 1'b0;
      flag_v    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        acc_out <= res;
        if (upd_nz) begin
          flag_n <= fres[23];
          flag_z <= (fres == 24'd0);
        end
        if (upd_tv) begin
          flag_t <= t_nx;
          flag_v <= v_nx;
        end
      end
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable({acc_out, flag_n, flag_z, flag_t, flag_v}));

  // R6
  cmp_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (opcode[7:3] == 5'b01010 || opcode[7:3] == 5'b01001)
    |=> acc_out == $past(acc_in));

  // R7
  logic_keeps_tv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (opcode[7:5] == 3'b101) |=> $stable({flag_t, flag_v}));

  // R8
  shift_keeps_tv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (opcode[7:5] == 3'b110) |=> $stable({flag_t, flag_v}));

  // R10
  ext8_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (opcode == 8'h59)
    |=> (acc_out[23:7] == 17'd0) || (&acc_out[23:7]));

endmodule

// File: tb/flag_alu24_tb.sv
`timescale 1ns/1ps
module flag_alu24_tb;

  logic        clk = 1'b0;
  logic        rst_n, in_valid;
  logic [7:0]  opcode, imm_in;
  logic [23:0] acc_in, reg_in;
  logic        out_valid, flag_n, flag_z, flag_t, flag_v;
  logic [23:0] acc_out;

  always #2.5 clk = ~clk;

  flag_alu24 u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .acc_in(acc_in), .reg_in(reg_in), .imm_in(imm_in),
    .out_valid(out_valid), .acc_out(acc_out),
    .flag_n(flag_n), .flag_z(flag_z), .flag_t(flag_t), .flag_v(flag_v)
  );

  int vectors = 0;
  int miscompares = 0;
  logic [23:0] eacc;
  logic        en, ez, et, ev;
  string       tag;

  logic [23:0] alist [8] = '{24'h000000, 24'h000001, 24'h7FFFFF, 24'h800000,
                             24'hFFFFFF, 24'h123456, 24'h00FF80, 24'h008000};
  logic [23:0] blist [8] = '{24'h000000, 24'h000001, 24'hFFFFFF, 24'h800000,
                             24'h7FFFFF, 24'h000018, 24'h000019, 24'h00002F};
  logic [7:0]  ilist [8] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF, 8'h17, 8'h18, 8'h1F};

  task automatic do_sub(input logic [23:0] x, input logic [23:0] y,
                        output logic [23:0] r, output logic t, output logic v);
    longint d;
    d = longint'($signed(x)) - longint'($signed(y));
    r = x - y;
    t = (x >= y);
    v = (d > 64'sd8388607) || (d < -64'sd8388608);
  endtask

  task automatic model();
    logic [23:0] raw, b, r, cres;
    longint      prod, am, s, u;
    logic        ct, cv;
    int          k;
    logic [4:0]  g;
    raw = opcode[2] ? {16'd0, imm_in} : reg_in;
    case (opcode[1:0])
      2'd0: prod = longint'(raw);
      2'd1: prod = longint'(raw) * 2;
      2'd2: prod = longint'(raw) * 256;
      default: prod = longint'(raw) * 65536;
    endcase
    b  = prod[23:0];
    am = opcode[2] ? longint'(imm_in[4:0]) : longint'(reg_in);
    g  = opcode[7:3];
    r  = acc_in;
    tag = "R11 other opcode";
    if (g == 5'b10000) begin
      s = longint'($signed(acc_in)) + longint'($signed(b));
      u = longint'(acc_in) + longint'(b);
      r = acc_in + b;
      et = (u > 64'sd16777215);
      ev = (s > 64'sd8388607) || (s < -64'sd8388608);
      en = r[23]; ez = (r == 0);
      tag = "R3 R4 R5 add";
    end else if (g == 5'b10010 || g == 5'b10001 || g == 5'b01010 || g == 5'b01001) begin
      if (g == 5'b10010 || g == 5'b01010) do_sub(acc_in, b, cres, ct, cv);
      else do_sub(b, acc_in, cres, ct, cv);
      et = ct; ev = cv; en = cres[23]; ez = (cres == 0);
      if (g[4]) begin r = cres; tag = "R3 R4 R5 subtract"; end
      else tag = "R3 R6 compare";
    end else if (opcode == 8'h59 || opcode == 8'h5A) begin
      r = (opcode == 8'h59) ? {{16{acc_in[7]}}, acc_in[7:0]} : {{8{acc_in[15]}}, acc_in[15:0]};
      en = r[23]; ez = (r == 0);
      tag = "R10 sign extend";
    end else if (opcode[7:5] == 3'b101) begin
      case (opcode[4:3])
        2'd0: r = ~(acc_in ^ b);
        2'd1: r = acc_in ^ b;
        2'd2: r = acc_in & b;
        default: r = acc_in | b;
      endcase
      en = r[23]; ez = (r == 0);
      tag = "R3 R7 logic";
    end else if (opcode[7:5] == 3'b110) begin
      case (opcode[4:3])
        2'd0: r = (am >= 24) ? 24'd0 : acc_in >> am;
        2'd1: begin
          r = acc_in;
          if (am >= 24) r = {24{acc_in[23]}};
          else for (int m = 0; m < am; m++) r = {r[23], r[23:1]};
        end
        2'd2: begin
          k = int'(am % 24);
          r = acc_in;
          for (int m = 0; m < k; m++) r = {r[0], r[23:1]};
        end
        default: r = (am >= 24) ? 24'd0 : acc_in << am;
      endcase
      en = r[23]; ez = (r == 0);
      tag = (am >= 24) ? "R8 R9 shift large" : "R8 shift";
    end
    eacc = r;
  endtask

  task automatic check(input string t, input logic ev_valid);
    vectors++;
    if (out_valid !== ev_valid || acc_out !== eacc ||
        {flag_n, flag_z, flag_t, flag_v} !== {en, ez, et, ev}) begin
      miscompares++;
      $display("FAIL %s op=%02h a=%06h r=%06h i=%02h: got v=%0b acc=%06h nztv=%b%b%b%b expected v=%0b acc=%06h nztv=%b%b%b%b",
               t, opcode, acc_in, reg_in, imm_in, out_valid, acc_out,
               flag_n, flag_z, flag_t, flag_v, ev_valid, eacc, en, ez, et, ev);
    end
  endtask

  initial begin
    #1ms;
    vectors++;
    miscompares++;
    $display("FAIL R2 watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; opcode = '0; acc_in = '0; reg_in = '0; imm_in = '0;
    eacc = '0; en = 1'b0; ez = 1'b0; et = 1'b0; ev = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset state", 1'b0);
    rst_n = 1'b1;
    for (int op = 0; op < 256; op++) begin
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          opcode = op[7:0]; acc_in = alist[i]; reg_in = blist[j]; imm_in = ilist[j];
          in_valid = 1'b1;
          model();
          @(negedge clk);
          check(tag, 1'b1);
        end
      end
      in_valid = 1'b0;
      opcode = 8'h80; acc_in = 24'hABCDEF; reg_in = 24'h111111;
      @(negedge clk);
      check("R2 idle hold", 1'b0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule